// File: doc/BRIEF.md
# Integer-Ratio Clock Enable Generator

This block lives in a fast clock domain and produces a one-cycle enable strobe that lets a slower, phase-aligned consumer (a bus port or a peripheral) advance only on every Nth fast cycle. A phase counter splits time into periods of N fast cycles. The first cycle of each period is the rising edge of the derived slow clock. The strobe fires a programmable number of fast cycles, the lead, ahead of the next such edge. A lead of one is the normal case. A lead of three gives time for propagation to a distant consumer.

The divide ratio and lead come in on plain inputs. They are taken only on the clock edge that closes a period. The period in progress therefore always ends at the ratio it started with, so the ratio can be retuned while the block runs, for example from 3:1 straight to 1:1, and no period comes out short or malformed. A configuration that cannot be met is refused and flagged, and the active one stays in force. A run input blanks all strobes so the consumer can idle in a low-power state. The phase counter keeps turning while run is low, so alignment is kept. The block also drives a model of the derived slow clock so that checkers can see where each period sits.

Top module: `clken_ratio_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, en, slow_clk and cfg_err are 0. The first period starts on the first clock edge after reset, using the ratio_in and lead_in values present at that edge, so no partial period occurs.
- R2: With active ratio N and lead L, a period is N fast cycles numbered 0 to N-1. Cycle 0 is the slow-clock rising edge. en is high in cycle N-L only, which is exactly L fast cycles before the next period's cycle 0. This holds while run is high and was high in the previous cycle.
- R3: With ratio 1 and lead 1, en is high in every cycle in which run is high and was high in the previous cycle.
- R4: Leads of 2 and 3 place the strobe 2 or 3 fast cycles ahead of the next slow-clock rising edge, for every ratio of at least the lead.
- R5: ratio_in and lead_in are sampled only on the edge that ends cycle N-1 of a period. Changes at any other time do not affect the period in progress.
- R6: A sampled configuration is illegal if the ratio is 0, the lead is 0, or the lead is greater than the ratio. An illegal configuration is not applied, and the previous ratio and lead stay active. cfg_err goes high from the next cycle and holds until the next period boundary, where it clears if the sampled configuration is legal.
- R7: slow_clk is high in cycles 0 to ceil(N/2)-1 of each period and low for the rest of the period. At ratio 1 it stays high.
- R8: en is 0 in any cycle in which run is 0, and also in the first cycle in which run is 1 again. The phase counter keeps advancing regardless of run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Global enable; low blanks all strobes |
| ratio_in | input | RW (4) | Requested fast-to-slow divide ratio |
| lead_in | input | LW (2) | Requested strobe lead in fast cycles |
| en | output | 1 | One-cycle clock-enable strobe |
| slow_clk | output | 1 | Model of the derived slow clock |
| cfg_err | output | 1 | Last sampled configuration was illegal |

## Verification
en and slow_clk are decoded from registered state. They respond in the same cycle to the phase, and to run, so en is judged in the cycle a change of run is applied. A new ratio or lead first shapes the cycle that follows the boundary edge, and cfg_err changes in that same cycle. The bench drives inputs 5 ns after each rising edge and samples 15 ns after it. A cycle-level arithmetic model advances on each edge from the inputs held across that edge, so every comparison falls in the cycle where the result is due. Sweeps cover every legal ratio from 1 to 8 with every legal lead, mid-period reprogramming, illegal requests and run toggling.

// File: rtl/clken_pkg.sv
// Shared helpers for the clock-enable generator.
// Assumes ratio and lead are unsigned and small enough to fit in an int.
package clken_pkg;

    // Legality rule: nonzero ratio, nonzero lead, lead no larger than ratio.
    function automatic logic cfg_legal(input int unsigned ratio, input int unsigned lead);
        return (ratio != 0) && (lead != 0) && (lead <= ratio);
    endfunction

endpackage

// File: rtl/clken_cfg_hold.sv
// Holds the active ratio and lead. Loads new values only when `load` is
// high, and only if they are legal. Otherwise it keeps the old pair and raises err.
// Assumes load is high for exactly one cycle per period boundary.
module clken_cfg_hold #(
    parameter int RW = 4,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] ratio_in,
    input  logic [LW-1:0] lead_in,
    output logic [RW-1:0] cur_ratio,
    output logic [LW-1:0] cur_lead,
    output logic          err
);
    import clken_pkg::*;

    logic ok;

    // Judge the requested pair against the legality rule.
    always_comb ok = cfg_legal(int'(ratio_in), int'(lead_in));

    // Latch a legal pair at a boundary, or flag a refused one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ratio <= RW'(1);
            cur_lead  <= LW'(1);
            err       <= 1'b0;
        end else if (load) begin
            if (ok) begin
                cur_ratio <= ratio_in;
                cur_lead  <= lead_in;
            end
            err <= !ok;
        end
    end
endmodule

// File: rtl/clken_phase_ctr.sv
// Counts the fast-cycle position within a slow period. It flags the last
// cycle of a period, and the first cycle after reset, as a load point.
// Assumes cur_ratio is at least 1 and changes only on a load edge.
module clken_phase_ctr #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] cur_ratio,
    output logic [RW-1:0] phase,
    output logic          started,
    output logic          load
);
    localparam logic [RW-1:0] ONE = RW'(1);

    // A boundary is the final cycle of a period, or the cycle before the first period.
    always_comb load = !started || (phase == cur_ratio - ONE);

    // Advance the phase, wrapping to zero at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            started <= 1'b0;
        end else begin
            started <= 1'b1;
            phase   <= load ? '0 : phase + ONE;
        end
    end
endmodule

// File: rtl/clken_strobe.sv
// Decodes the enable strobe and the slow-clock model from the phase.
// The strobe is blanked while run is low and in the first cycle that run is high again.
// Assumes 1 <= cur_lead <= cur_ratio and LW <= RW.
module clken_strobe #(
    parameter int RW = 4,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          started,
    input  logic [RW-1:0] phase,
    input  logic [RW-1:0] cur_ratio,
    input  logic [LW-1:0] cur_lead,
    output logic          en,
    output logic          slow_clk
);
    logic          run_q;
    logic [RW-1:0] fire_at;
    logic [RW:0]   high_len;

    // Remember whether run was high in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // Strobe position and high-phase length of the slow clock.
    always_comb begin
        fire_at  = cur_ratio - {{(RW-LW){1'b0}}, cur_lead};
        high_len = ({1'b0, cur_ratio} + {{RW{1'b0}}, 1'b1}) >> 1;
    end

    // Output decode.
    always_comb begin
        en       = started && run && run_q && (phase == fire_at);
        slow_clk = started && ({1'b0, phase} < high_len);
    end
endmodule

// File: rtl/clken_ratio_gen.sv
// Top of the integer-ratio clock-enable generator: configuration hold,
// phase counter and strobe decode. The configuration is taken only at period boundaries.
// Assumes a single fast clock and a synchronous active-low reset.
module clken_ratio_gen #(
    parameter int RW = 4,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] ratio_in,
    input  logic [LW-1:0] lead_in,
    output logic          en,
    output logic          slow_clk,
    output logic          cfg_err
);
    logic [RW-1:0] cur_ratio;
    logic [LW-1:0] cur_lead;
    logic [RW-1:0] phase;
    logic          started;
    logic          load;

    clken_cfg_hold #(.RW(RW), .LW(LW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ratio_in(ratio_in), .lead_in(lead_in),
        .cur_ratio(cur_ratio), .cur_lead(cur_lead), .err(cfg_err)
    );

    clken_phase_ctr #(.RW(RW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .cur_ratio(cur_ratio),
        .phase(phase), .started(started), .load(load)
    );

    clken_strobe #(.RW(RW), .LW(LW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .run(run), .started(started),
        .phase(phase), .cur_ratio(cur_ratio), .cur_lead(cur_lead),
        .en(en), .slow_clk(slow_clk)
    );
endmodule

// File: rtl/clken_ratio_gen_chk.sv
// Property checker for clken_ratio_gen, attached by bind.
module clken_ratio_gen_chk #(
    parameter int RW = 4,
    parameter int LW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          en,
    input logic          slow_clk,
    input logic          cfg_err,
    input logic          started,
    input logic [RW-1:0] phase,
    input logic [RW-1:0] cur_ratio,
    input logic [LW-1:0] cur_lead
);
    // R1
    strobe_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> started);

    // R2
    phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < cur_ratio);

    // R3
    unity_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && cur_ratio == RW'(1) && run && $past(run)) |-> en);

    // R5
    mid_period_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> ($stable(cur_ratio) && $stable(cur_lead)));

    // R6
    refused_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($stable(cur_ratio) && $stable(cur_lead)));

    // R7
    unity_slow_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && cur_ratio == RW'(1)) |-> slow_clk);

    // R8
    idle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !en);

    // R8
    resume_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $past(run));
endmodule

bind clken_ratio_gen clken_ratio_gen_chk #(.RW(RW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .en(en), .slow_clk(slow_clk),
    .cfg_err(cfg_err), .started(started), .phase(phase),
    .cur_ratio(cur_ratio), .cur_lead(cur_lead)
);

// File: tb/sim_clken_ratio_gen.sv
`timescale 1ns/1ps
module sim_clken_ratio_gen;
    localparam int RW = 4;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [RW-1:0] ratio_in = '0;
    logic [LW-1:0] lead_in = '0;
    logic          en, slow_clk, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;

    // Arithmetic model state
    int  m_ph = 0, m_r = 1, m_l = 1;
    bit  m_started = 0, m_err = 0, m_runq = 0;

    always #10 clk = ~clk;

    clken_ratio_gen #(.RW(RW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .ratio_in(ratio_in),
        .lead_in(lead_in), .en(en), .slow_clk(slow_clk), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: got %0d expected %0d", tag, what, $time, act, exp);
        end
    endtask

    // One fast cycle: sample 15 ns after the edge, compare, advance the model, re-align.
    task automatic cyc(input string tag);
        bit e_en, e_slow;
        #10;
        e_en   = m_started && run && m_runq && (m_ph == m_r - m_l);
        e_slow = m_started && (m_ph < (m_r + 1) / 2);
        chk(tag, "en", en, e_en);
        chk((tag == "R1") ? "R1" : "R7", "slow_clk", slow_clk, e_slow);
        chk((tag == "R1") ? "R1" : "R6", "cfg_err", cfg_err, m_err);
        if (rst_n) begin
            if (!m_started || m_ph == m_r - 1) begin
                if (ratio_in != 0 && lead_in != 0 && int'(lead_in) <= int'(ratio_in)) begin
                    m_r = int'(ratio_in);
                    m_l = int'(lead_in);
                    m_err = 0;
                end else begin
                    m_err = 1;
                end
                m_ph = 0;
                m_started = 1;
            end else begin
                m_ph++;
            end
            m_runq = run;
        end
        @(posedge clk);
        #5;
    endtask

    task automatic cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk);
        #5;
        // R1: outputs quiet in reset even with run high
        run = 1'b1;
        ratio_in = 4'd3;
        lead_in = 2'd1;
        cycles(3, "R1");
        rst_n = 1'b1;
        cyc("R1");
        cycles(12, "R2");

        // R2 R3 R4 R7: sweep all legal ratio/lead pairs
        for (int r = 1; r <= 8; r++) begin
            for (int l = 1; l <= 3; l++) begin
                if (l <= r) begin
                    ratio_in = RW'(r);
                    lead_in = LW'(l);
                    cycles(4 * r + 3, (r == 1) ? "R3" : ((l > 1) ? "R4" : "R2"));
                end
            end
        end

        // R5: reprogram mid-period, including 3:1 straight to 1:1
        ratio_in = 4'd5; lead_in = 2'd2;
        cycles(12, "R5");
        ratio_in = 4'd2; lead_in = 2'd1;
        cycles(9, "R5");
        ratio_in = 4'd3; lead_in = 2'd1;
        cycles(7, "R5");
        ratio_in = 4'd1; lead_in = 2'd1;
        cycles(6, "R5");
        ratio_in = 4'd7; lead_in = 2'd3;
        cycles(3, "R5");
        ratio_in = 4'd4; lead_in = 2'd1;
        cycles(2, "R5");
        ratio_in = 4'd6; lead_in = 2'd2;
        cycles(14, "R5");

        // R6: illegal requests keep the old configuration
        ratio_in = 4'd0; lead_in = 2'd1;
        cycles(14, "R6");
        ratio_in = 4'd4; lead_in = 2'd0;
        cycles(14, "R6");
        ratio_in = 4'd2; lead_in = 2'd3;
        cycles(14, "R6");
        ratio_in = 4'd2; lead_in = 2'd2;
        cycles(10, "R6");

        // R8: run gating and one-cycle resume delay, counter keeps turning
        ratio_in = 4'd3; lead_in = 2'd1;
        cycles(6, "R8");
        run = 1'b0;
        cycles(7, "R8");
        run = 1'b1;
        cycles(8, "R8");
        ratio_in = 4'd1;
        cycles(4, "R8");
        run = 1'b0;
        cyc("R8");
        run = 1'b1;
        cycles(5, "R8");
        for (int k = 0; k < 10; k++) begin
            run = k[0];
            cyc("R8");
        end
        run = 1'b1;
        cycles(4, "R8");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule